// File: doc/BRIEF.md
# Sequential Integer Multiplier with Per-Operand Signedness

This block multiplies two integer operands one multiplier bit per clock cycle and returns a single register-width result. Each operand can be read as signed or unsigned, depending on a 2-bit selector. The full double-width product is always formed. The result is either its lower half or its upper half, so the upper half is exact for every signedness combination. A separate word flag selects a narrow mode. In that mode only the lower half-width of each operand is used, both values are read as signed, and the low half-width of their product is sign-extended to the full width.

Requests arrive on a valid/ready input port. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle. It is low while a multiply is running and while a finished result is waiting. The result is offered on a valid/ready output port. `out_valid` and `out_data` hold steady until the consumer raises `out_ready`. Only after that transfer does the unit accept a new request. A consumer can stall for any number of cycles without losing the result, and the producer's pending request is simply held off. `rst` is synchronous and active high.

Top module: `imul_seq`

## Requirements
- R1: A request is accepted only on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when no multiply is running and no result is pending. A request that is held during a stall is taken after the stall and computed correctly.
- R2: With `in_word`=0 and `in_func[1:0]`=00, `out_data` is the low XLEN bits of the product, with both operands read as signed. This half is identical for every signedness.
- R3: With `in_word`=0 and `in_func[1:0]`=01, `out_data` is bits 2·XLEN-1..XLEN of the exact product of two signed operands.
- R4: With `in_word`=0 and `in_func[1:0]`=10, `out_data` is the upper half of the product of signed `in_a` and unsigned `in_b`.
- R5: With `in_word`=0 and `in_func[1:0]`=11, `out_data` is the upper half of the product of two unsigned operands.
- R6: With `in_word`=1, bits HALF-1..0 of each operand are read as signed. Bits HALF-1..0 of their product are sign-extended to XLEN bits. `in_func` has no effect in this mode.
- R7: `in_func[2]` has no effect on the result. A code with bit 2 set gives the same result as the same code with bit 2 clear.
- R8: Counted from the accepting edge, `out_valid` rises on edge XLEN+1 in full mode and on edge HALF+1 in word mode.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1, `out_data` stays unchanged and `in_ready` stays 0, whatever is on the input port.
- R10: A rising edge with `rst`=1 abandons any multiply in progress. After reset, `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_a | input | XLEN | First operand (multiplicand) |
| in_b | input | XLEN | Second operand (multiplier) |
| in_func | input | 3 | Half and signedness selector, bit 2 ignored |
| in_word | input | 1 | 1 selects word mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Result |

## Verification
Two things can happen in the same cycle: a new request is offered on the input port, and a finished result is still held under output back-pressure. The bench provokes this by keeping `out_ready` low for several cycles with `in_valid` high and a different operand pair on the input. It judges the case by checking, in every stalled cycle, that `in_ready` stays low and `out_data` keeps the first result. It then releases the stall and checks that the held request is taken next and produces its own correct product. Around this, a near-exhaustive sweep of boundary operand values covers every selector and word mode on a 16-bit configuration. Each result is compared against products computed in plain integer arithmetic.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_DONE = 2'd3
  } imul_state_e;

  typedef enum logic [1:0] {
    SEL_LO  = 2'b00,
    SEL_HSS = 2'b01,
    SEL_HSU = 2'b10,
    SEL_HUU = 2'b11
  } imul_sel_e;

endpackage

// File: rtl/imul_prep.sv
module imul_prep
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      sel,
  input  logic            word,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg,
  output logic            hi
);

  logic [XLEN-1:0] raw [2];
  logic            sgn [2];
  logic [XLEN-1:0] mag [2];
  logic            isneg [2];

  always_comb begin
    if (word) begin
      raw[0] = {{(XLEN-HALF){a[HALF-1]}}, a[HALF-1:0]};
      raw[1] = {{(XLEN-HALF){b[HALF-1]}}, b[HALF-1:0]};
      sgn[0] = 1'b1;
      sgn[1] = 1'b1;
      hi     = 1'b0;
    end else begin
      raw[0] = a;
      raw[1] = b;
      sgn[0] = (sel != SEL_HUU);
      sgn[1] = (sel == SEL_LO) || (sel == SEL_HSS);
      hi     = (sel != SEL_LO);
    end
  end

  // Per-operand sign/magnitude conversion
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    assign isneg[g] = sgn[g] & raw[g][XLEN-1];
    assign mag[g]   = isneg[g] ? (~raw[g] + 1'b1) : raw[g];
  end

  assign mag_a = mag[0];
  assign mag_b = mag[1];
  assign neg   = isneg[0] ^ isneg[1];

endmodule

// File: rtl/imul_core.sv
module imul_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              load,
  input  logic              step,
  input  logic [XLEN-1:0]   mcand,
  input  logic [XLEN-1:0]   mplier,
  output logic [2*XLEN-1:0] prod
);

  logic [XLEN-1:0] acc_hi;
  logic [XLEN-1:0] acc_lo;
  logic [XLEN-1:0] mc_q;
  logic [XLEN:0]   sum;

  // Add the multiplicand when the current multiplier bit is set
  assign sum = {1'b0, acc_hi} + {1'b0, (acc_lo[0] ? mc_q : {XLEN{1'b0}})};

  always_ff @(posedge clk) begin
    if (load) begin
      acc_hi <= '0;
      acc_lo <= mplier;
      mc_q   <= mcand;
    end else if (step) begin
      acc_hi <= sum[XLEN:1];
      acc_lo <= {sum[0], acc_lo[XLEN-1:1]};
    end
  end

  assign prod = {acc_hi, acc_lo};

endmodule

// File: rtl/imul_fix.sv
module imul_fix #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [2*XLEN-1:0] prod,
  input  logic              neg,
  input  logic              hi,
  input  logic              word,
  output logic [XLEN-1:0]   result
);

  logic [2*XLEN-1:0] full;
  logic [HALF-1:0]   wp;
  logic [HALF-1:0]   wn;

  assign full = neg ? (~prod + 1'b1) : prod;
  // After HALF steps the narrow product sits just below the midpoint
  assign wp   = prod[XLEN-1 -: HALF];
  assign wn   = neg ? (~wp + 1'b1) : wp;

  always_comb begin
    if (word)    result = {{(XLEN-HALF){wn[HALF-1]}}, wn};
    else if (hi) result = full[2*XLEN-1:XLEN];
    else         result = full[XLEN-1:0];
  end

endmodule

// File: rtl/imul_seq.sv
module imul_seq
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [2:0]      in_func,
  input  logic            in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);

  localparam int CNT_W = $clog2(XLEN + 1);

  imul_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic              word_q, hi_q, neg_q;
  logic [XLEN-1:0]   mag_a, mag_b;
  logic              p_neg, p_hi;
  logic [2*XLEN-1:0] prod;
  logic [XLEN-1:0]   fixed;
  logic              accept, step;
  logic              func_unused;

  assign func_unused = in_func[2];
  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_DONE);
  assign accept      = in_valid && in_ready;
  assign step        = (state == ST_RUN);

  imul_prep #(.XLEN(XLEN), .HALF(HALF)) u_prep (
    .a(in_a), .b(in_b), .sel(in_func[1:0]), .word(in_word),
    .mag_a(mag_a), .mag_b(mag_b), .neg(p_neg), .hi(p_hi)
  );

  imul_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .load(accept), .step(step),
    .mcand(mag_a), .mplier(mag_b), .prod(prod)
  );

  imul_fix #(.XLEN(XLEN), .HALF(HALF)) u_fix (
    .prod(prod), .neg(neg_q), .hi(hi_q), .word(word_q), .result(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      word_q   <= 1'b0;
      hi_q     <= 1'b0;
      neg_q    <= 1'b0;
      out_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_RUN;
          cnt    <= in_word ? CNT_W'(HALF) : CNT_W'(XLEN);
          word_q <= in_word;
          hi_q   <= p_hi;
          neg_q  <= p_neg;
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          out_data <= fixed;
          state    <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/imul_seq_chk.sv
module imul_seq_chk #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_word,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data
);

  logic [31:0] lat;
  logic        wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= '0;
      wd  <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat <= '0;
      wd  <= in_word;
    end else if (!out_valid) begin
      lat <= lat + 1'b1;
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_excl_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_sext_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wd) |->
      ((out_data[XLEN-1:HALF-1] == '0) || (out_data[XLEN-1:HALF-1] == '1)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (lat == (wd ? HALF + 1 : XLEN + 1)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

endmodule

bind imul_seq imul_seq_chk #(.XLEN(XLEN), .HALF(HALF)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/imul_seq_bench.sv
`timescale 1ns/1ps
module imul_seq_bench;

  localparam int XW = 16;
  localparam int H  = XW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [XW-1:0] in_a = '0;
  logic [XW-1:0] in_b = '0;
  logic [2:0]    in_func = '0;
  logic          in_word = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [XW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  imul_seq #(.XLEN(XW), .HALF(H)) u_imul_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_func(in_func), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [XW-1:0] model(input logic [XW-1:0] a, input logic [XW-1:0] b,
                                          input logic [2:0] f, input logic w);
    longint pa, pb;
    logic [63:0] p;
    if (w) begin
      pa = longint'($signed(a[H-1:0]));
      pb = longint'($signed(b[H-1:0]));
      p  = pa * pb;
      return {{(XW-H){p[H-1]}}, p[H-1:0]};
    end
    pa = (f[1:0] != 2'b11) ? longint'($signed(a)) : longint'($unsigned(a));
    pb = (f[1:0] == 2'b00 || f[1:0] == 2'b01) ? longint'($signed(b)) : longint'($unsigned(b));
    p  = pa * pb;
    return (f[1:0] == 2'b00) ? p[XW-1:0] : p[2*XW-1:XW];
  endfunction

  function automatic string req_of(input logic [2:0] f, input logic w);
    if (w) return "R6";
    case (f[1:0])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic issue(input logic [XW-1:0] a, input logic [XW-1:0] b,
                       input logic [2:0] f, input logic w);
    @(negedge clk);
    in_a = a; in_b = b; in_func = f; in_word = w; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_result(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      #1;
    end while (!out_valid && lat < 200);
  endtask

  task automatic consume();
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic run_op(input logic [XW-1:0] a, input logic [XW-1:0] b,
                        input logic [2:0] f, input logic w, input string req);
    int lat;
    logic [XW-1:0] exp;
    exp = model(a, b, f, w);
    issue(a, b, f, w);
    wait_result(lat);
    check(out_data == exp, req, longint'(out_data), longint'(exp));
    check(lat == (w ? H + 1 : XW + 1), "R8", lat, w ? H + 1 : XW + 1);
    consume();
  endtask

  logic [XW-1:0] vals [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                               16'h8000, 16'h8001, 16'hFFFF, 16'hFFFE,
                               16'h00FF, 16'h0080, 16'h007F, 16'hFF80,
                               16'h1234, 16'hABCD, 16'h5555, 16'hAAAA};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [XW-1:0] ea, eb;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);

    // Sweep of boundary values over every mode
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int m = 0; m < 5; m++)
          run_op(vals[i], vals[j], (m < 4) ? 3'(m) : 3'b000, (m == 4), req_of(3'(m), m == 4));

    // R6: selector has no effect in word mode
    for (int i = 0; i < 16; i++)
      run_op(vals[i], vals[15 - i], 3'b011, 1'b1, "R6 func ignored in word mode");

    // R7: bit 2 of the selector is ignored
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++)
        run_op(vals[i], vals[(i + 5) % 16], 3'(4 + m), 1'b0, "R7 func[2] ignored");

    // R9 / R1: stalled result with a competing request offered
    ea = model(16'h8000, 16'h8000, 3'b001, 1'b0);
    eb = model(16'h1234, 16'hFFFF, 3'b011, 1'b0);
    issue(16'h8000, 16'h8000, 3'b001, 1'b0);
    wait_result(lat);
    @(negedge clk);
    in_a = 16'h1234; in_b = 16'hFFFF; in_func = 3'b011; in_word = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      check(out_valid == 1'b1, "R9 out_valid held", out_valid, 1);
      check(out_data == ea, "R9 out_data held", out_data, ea);
      check(in_ready == 1'b0, "R9 in_ready low while stalled", in_ready, 0);
    end
    @(negedge clk) out_ready = 1'b1;
    @(posedge clk); #1 out_ready = 1'b0;
    check(in_ready == 1'b1, "R1 idle after transfer", in_ready, 1);
    @(posedge clk); #1 in_valid = 1'b0;
    check(in_ready == 1'b0, "R1 held request accepted", in_ready, 0);
    wait_result(lat);
    check(out_data == eb, "R1 held request result", out_data, eb);
    consume();

    // R10: reset in the middle of a multiply
    issue(16'h7FFF, 16'h7FFF, 3'b001, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R10 in_ready after mid-op reset", in_ready, 1);
    check(out_valid == 1'b0, "R10 out_valid after mid-op reset", out_valid, 0);
    run_op(16'hFFFF, 16'h8000, 3'b010, 1'b0, "R4 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule